// File: doc/BRIEF.md
# Fixed-Point Add/AND Execution Unit with Condition Code

This unit is the integer adder stage of a 32-bit register-architecture processor. Each strobed operation takes a 32-bit first operand and a second operand that the pipeline has already fetched. It computes a signed full-word add, a signed add of a sign-extended halfword, an unsigned (logical) add or a bitwise AND. The 32-bit result is returned for write-back into the first-operand register.

Alongside the result the unit produces a 2-bit condition code. For the signed forms the code separates zero, negative, positive and overflow results. For the logical add the code combines a zero/nonzero result with carry/no carry. For AND the code shows whether any result bit is set. A signed overflow raises a fixed-point-overflow interruption request, but only when the caller's mask bit permits it. All three outputs are registered and are updated on the clock edge that samples the valid strobe.

Top module: `fxadd_cc_unit`

## Requirements
- R1: Operation select `op_sel` is 2 bits: 0 = signed word add, 1 = signed halfword add, 2 = logical add, 3 = AND. The result is (a+b) mod 2^32 for codes 0 and 2, and (a + sign-extended b[15:0]) mod 2^32 for code 1. Bits b[31:16] are ignored for code 1.
- R2: For code 3 the result is the bitwise AND of a and b. The condition code is 0 when the result is zero and 1 otherwise.
- R3: For signed adds (codes 0 and 1) with no overflow, the condition code is 0 for a zero sum, 1 for a negative sum and 2 for a positive sum.
- R4: A signed overflow (both addends have the same sign and the sum sign differs) sets the condition code to 3. The truncated sum is still written.
- R5: `ovf_irq` is 1 only for a signed overflow with `ovf_mask`=1. A signed overflow with mask 0 gives 0.
- R6: For the logical add, cc = {carry-out, sum nonzero}: 0 = zero/no carry, 1 = nonzero/no carry, 2 = zero/carry, 3 = nonzero/carry. The logical add never raises `ovf_irq`.
- R7: The outputs update on the rising edge where `in_valid`=1. They hold their values when `in_valid`=0.
- R8: While `rst_n` is low, the result, condition code and `ovf_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code (see R1) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (low half used for the halfword form) |
| ovf_mask | input | 1 | Fixed-point-overflow interruption mask |
| res_q | output | 32 | Registered result |
| cc_q | output | 2 | Registered condition code |
| ovf_irq_q | output | 1 | Registered overflow interruption request |

## Verification
The embedded assertions check the following relations between the registered outputs on every cycle: an interruption implies condition code 3, outputs hold when no strobe is present, the AND code never exceeds 1, and reset clears everything. The bench's reference model is needed to show correct sums, halfword sign extension, the carry/zero matrix of the logical add, and that the mask changes only the interruption and never the code.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;
  typedef enum logic [1:0] {
    OP_ADDW  = 2'd0,
    OP_ADDH  = 2'd1,
    OP_ADDL  = 2'd2,
    OP_AND   = 2'd3
  } fx_op_e;

  typedef struct packed {
    logic [1:0] cc;
    logic       irq;
  } fx_flags_t;
endpackage

// File: rtl/fxadd_operand_prep.sv
module fxadd_operand_prep
  import fxadd_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  fx_op_e         op,
  input  logic [W-1:0]   b_in,
  output logic [W-1:0]   b_out
);
  always_comb begin
    if (op == OP_ADDH) b_out = {{(W-HW){b_in[HW-1]}}, b_in[HW-1:0]};
    else               b_out = b_in;
  end
endmodule

// File: rtl/fxadd_core.sv
module fxadd_core
  import fxadd_pkg::*;
#(
  parameter int W = 32
) (
  input  fx_op_e        op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          mask,
  output logic [W-1:0]  res,
  output fx_flags_t     flags
);
  logic [W:0] sum_ext;
  logic       sovf;
  logic       nz;

  always_comb begin
    sum_ext = {1'b0, a} + {1'b0, b};
    sovf    = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
    res     = (op == OP_AND) ? (a & b) : sum_ext[W-1:0];
    nz      = |res;
    flags   = '0;
    unique case (op)
      OP_ADDW, OP_ADDH: begin
        if (sovf)            flags.cc = 2'd3;
        else if (!nz)        flags.cc = 2'd0;
        else if (res[W-1])   flags.cc = 2'd1;
        else                 flags.cc = 2'd2;
        flags.irq = sovf & mask;
      end
      OP_ADDL: flags.cc = {sum_ext[W], nz};
      default: flags.cc = {1'b0, nz};
    endcase
  end
endmodule

// File: rtl/fxadd_cc_unit.sv
module fxadd_cc_unit
  import fxadd_pkg::*;
#(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic          ovf_mask,
  output logic [W-1:0]  res_q,
  output logic [1:0]    cc_q,
  output logic          ovf_irq_q
);
  logic          rst_s1, rst_sync_n;
  fx_op_e        op;
  logic [W-1:0]  b_prep, res_d;
  fx_flags_t     flags_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign op = fx_op_e'(op_sel);

  fxadd_operand_prep #(.W(W), .HW(HW)) u_prep (
    .op(op), .b_in(opnd_b), .b_out(b_prep)
  );

  fxadd_core #(.W(W)) u_core (
    .op(op), .a(opnd_a), .b(b_prep), .mask(ovf_mask),
    .res(res_d), .flags(flags_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q     <= '0;
      cc_q      <= '0;
      ovf_irq_q <= 1'b0;
    end else if (in_valid) begin
      res_q     <= res_d;
      cc_q      <= flags_d.cc;
      ovf_irq_q <= flags_d.irq;
    end
  end

  assert_irq_cc3_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_irq_q |-> (cc_q == 2'd3));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) && !$past(in_valid) |-> $stable(res_q) && $stable(cc_q) && $stable(ovf_irq_q));
  assert_and_cc_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && op == OP_AND |=> cc_q <= 2'd1 && !ovf_irq_q);
  assert_logical_noirq_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && op == OP_ADDL |=> !ovf_irq_q);
  assert_reset_R8: assert property (@(posedge clk)
    !rst_sync_n |-> res_q == '0 && cc_q == 2'd0 && !ovf_irq_q);
endmodule

// File: tb/fxadd_cc_unit_bench.sv
module fxadd_cc_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [1:0]  op_sel = 0;
  logic [31:0] opnd_a = 0, opnd_b = 0;
  logic        ovf_mask = 0;
  logic [31:0] res_q;
  logic [1:0]  cc_q;
  logic        ovf_irq_q;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_res = 0;
  logic [1:0]  exp_cc = 0;
  logic        exp_irq = 0;

  always #4 clk = ~clk;

  fxadd_cc_unit u_fxadd_cc_unit (.*);

  task automatic chk(string req);
    checks++;
    if (res_q !== exp_res || cc_q !== exp_cc || ovf_irq_q !== exp_irq) begin
      fails++;
      $display("FAIL %s: got res=%h cc=%0d irq=%0b exp res=%h cc=%0d irq=%0b",
               req, res_q, cc_q, ovf_irq_q, exp_res, exp_cc, exp_irq);
    end
  endtask

  function automatic void model(int op, logic [31:0] a, logic [31:0] b, logic m);
    longint sa, sb, s;
    longint unsigned u;
    if (op == 3) begin
      exp_res = a & b; exp_cc = (exp_res != 0) ? 1 : 0; exp_irq = 0;
      return;
    end
    if (op == 2) begin
      u = longint'(a) + longint'(b);
      exp_res = u[31:0]; exp_irq = 0;
      exp_cc = {u[32], exp_res != 0};
      return;
    end
    sa = longint'(signed'(a));
    sb = (op == 1) ? longint'(signed'(b[15:0])) : longint'(signed'(b));
    s = sa + sb;
    exp_res = s[31:0];
    if (s > 64'sd2147483647 || s < -64'sd2147483648) begin
      exp_cc = 3; exp_irq = m;
    end else begin
      exp_irq = 0;
      exp_cc = (s == 0) ? 0 : (s < 0) ? 1 : 2;
    end
  endfunction

  task automatic op_run(int op, logic [31:0] a, logic [31:0] b, logic m, string req);
    @(negedge clk);
    op_sel = op[1:0]; opnd_a = a; opnd_b = b; ovf_mask = m; in_valid = 1;
    model(op, a, b, m);
    @(negedge clk);
    in_valid = 0;
    chk(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R8");
    op_run(0, 32'd5, 32'd7, 1, "R1");
    op_run(0, 32'd5, 32'hFFFF_FFFB, 1, "R3 zero");
    op_run(0, 32'd5, 32'hFFFF_FFF0, 1, "R3 neg");
    op_run(0, 32'h7FFF_FFFF, 32'd1, 1, "R4 R5 ovf masked-on");
    op_run(0, 32'h8000_0000, 32'h8000_0000, 0, "R4 R5 ovf mask0");
    op_run(1, 32'd10, 32'h1234_FFFF, 1, "R1 halfword sext");
    op_run(1, 32'h7FFF_FFFF, 32'h0000_0001, 1, "R4 halfword ovf");
    op_run(1, 32'd3, 32'hFFFF_8000, 0, "R3 halfword neg");
    op_run(2, 32'd0, 32'd0, 1, "R6 cc0");
    op_run(2, 32'd1, 32'd2, 1, "R6 cc1");
    op_run(2, 32'hFFFF_FFFF, 32'd1, 1, "R6 cc2");
    op_run(2, 32'h8000_0000, 32'h8000_0001, 1, "R6 cc3 noirq");
    op_run(3, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, "R2 zero");
    op_run(3, 32'hFFFF_0000, 32'h00FF_FF00, 1, "R2 nonzero");
    // R7: no strobe, outputs hold
    @(negedge clk);
    op_sel = 0; opnd_a = 32'h7FFF_FFFF; opnd_b = 1; ovf_mask = 1; in_valid = 0;
    repeat (2) @(negedge clk);
    chk("R7 hold");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      op_run(i % 4, ra, rb, i[2], "R1 R3 R6 random");
    end
    @(negedge clk);
    rst_n = 0;
    exp_res = 0; exp_cc = 0; exp_irq = 0;
    @(negedge clk);
    chk("R8 reset again");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule